// File: doc/BRIEF.md
# Serial Port Enable Control

This block is an asynchronous serial transmitter/receiver pair behind a small register bus, built around what happens as the transmit and receive sides are switched on and off. Software picks the bit-rate source and clock-pin behaviour, the character format and the divisor, then enables either side. Switching the transmitter on first produces one whole character time of idle line before any data leaves. Switching it off discards pending data and reports the data buffer as empty. Switching the receiver off freezes the receive flags and the last received byte exactly as they were.

A clocked synchronous mode exists only as far as its clock pin goes: in that mode the serial engines stay idle, and the clock pin is driven only when the receiver is enabled. The transmit pin is driven only when a separate pin-enable register bit is set. An external clock can replace the internal divisor as the 16x oversampling source.

Top module: `sio_core`

## Requirements
- R1: After reset, the status register (address 3) reads 0x01, the control register (address 0) reads 0x00, `txd_out` is 1, and `txd_oe` and `sclk_oe` are 0. Status bits: bit0 transmit buffer empty, bit1 receive full, bit2 parity error, bit3 framing error, bit4 overrun.
- R2: `txd_oe` follows bit0 of the pin register (address 6). While the transmitter is idle, `txd_out` is 1.
- R3: After control bit0 (transmit on) goes from 0 to 1, `txd_out` stays 1 for one full character time before the first start bit. The character time is the frame bit count times 16 oversampling ticks.
- R4: A transmitted frame is a 0 start bit, then data LSB first, then an optional parity bit, then stop bits of 1. Each bit lasts 16 ticks, and one tick comes every (divisor + 1) clocks. The divisor is at address 2. Format register (address 1): bit0 seven data bits, bit1 parity on, bit2 odd parity, bit3 two stop bits, bit4 synchronous mode.
- R5: A write to the transmit buffer (address 4) while transmit is on clears the empty flag. The flag returns to 1 when the byte moves into the shifter.
- R6: Clearing transmit-on forces the empty flag to 1 and returns `txd_out` to 1, even in the middle of a frame.
- R7: While control bit1 (receive on) is set, the receiver hunts for a start bit and samples each bit at its middle. It then sets receive-full and stores the byte, which is read at address 5. Reading address 5 clears receive-full. While receive-on is clear, frames on `rxd_in` are ignored.
- R8: A frame that completes while receive-full is set raises overrun and leaves the stored byte unchanged.
- R9: A stop bit sampled as 0 sets the framing error, and a parity mismatch sets the parity error. Error flags stay set until status is written with a 0 in their bit. Writing 1 leaves them unchanged.
- R10: Clearing receive-on leaves receive-full, parity error, framing error, overrun and the stored byte unchanged.
- R11: In asynchronous mode with clock select (control bits 3:2) = 01, `sclk_oe` is 1 the cycle after that write, whatever the enable bits are. `sclk_out` toggles every 8 ticks.
- R12: In synchronous mode with clock select = 01, `sclk_oe` is 1 only while receive-on is also set.
- R13: With clock select = 1x, the divisor is ignored: each rising edge of `ext_clk_in` is one tick and `sclk_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| ext_clk_in | input | 1 | External 16x oversampling clock |
| sclk_out | output | 1 | Serial clock output value |
| sclk_oe | output | 1 | Serial clock pin drive enable |
| txd_out | output | 1 | Transmit line value |
| txd_oe | output | 1 | Transmit pin drive enable |
| rxd_in | input | 1 | Receive line |

## Verification
Register and pin-enable effects (`sclk_oe`, `txd_oe`, the empty flag after a buffer write or after a disable) appear on the clock edge that takes the write. The bench samples them at the falling edge right after its write task. The first start bit follows the transmit enable by 160 ticks plus two clocks of pipeline, and the ticks are measured at the falling edge in a small window around that count. Received flags settle at the middle of the stop bit plus a two-stage input synchronizer. The bench therefore reads status only after the whole frame and some idle time have passed. Captured transmit bits are sampled in the middle of each bit period, counted from the detected falling edge.

// File: rtl/sio_pkg.sv
// Shared constants, the format type and the frame helpers for the serial port.
// Assumes a byte-wide register bus and at most 12 frame bits.
package sio_pkg;
    localparam int DATA_W  = 8;
    localparam int BUS_W   = 8;
    localparam int RATE_W  = 8;
    localparam int OSR     = 16;
    localparam int FRAME_W = DATA_W + 4;
    localparam int SUB_W   = $clog2(OSR);
    localparam int IDX_W   = $clog2(FRAME_W + 1);

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_FMT   = 3'd1;
    localparam logic [2:0] A_RATE  = 3'd2;
    localparam logic [2:0] A_STAT  = 3'd3;
    localparam logic [2:0] A_TXBUF = 3'd4;
    localparam logic [2:0] A_RXBUF = 3'd5;
    localparam logic [2:0] A_PIN   = 3'd6;

    typedef struct packed {
        logic sync;
        logic two_stop;
        logic par_odd;
        logic par_en;
        logic len7;
    } fmt_t;

    // Number of data bits in the selected format
    function automatic int data_len(fmt_t f);
        return f.len7 ? DATA_W - 1 : DATA_W;
    endfunction

    // Total bits in one frame, start through last stop bit
    function automatic logic [IDX_W-1:0] frame_bits(fmt_t f);
        return IDX_W'(1 + data_len(f) + (f.par_en ? 1 : 0) + (f.two_stop ? 2 : 1));
    endfunction

    // Frame bits in send order, LSB first; unused upper positions are ones
    function automatic logic [FRAME_W-1:0] build_frame(logic [DATA_W-1:0] d, fmt_t f);
        logic [FRAME_W-1:0] fr;
        logic p;
        int n;
        fr = '1;
        p  = f.par_odd;
        n  = data_len(f);
        fr[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n) begin
                fr[1 + i] = d[i];
                p = p ^ d[i];
            end
        end
        if (f.par_en) fr[1 + n] = p;
        return fr;
    endfunction
endpackage

// File: rtl/sio_baud.sv
// Oversampling tick source and bit-rate clock for the clock pin.
// Assumes ext_clk_in is slower than clk/2; it is synchronised here.
module sio_baud #(
    parameter int RATE_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_sel,
    input  logic [RATE_W-1:0] rate,
    input  logic              ext_clk,
    output logic              tick,
    output logic              bit_clk
);
    localparam int HALF_W = $clog2(OSR / 2);
    localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(OSR / 2 - 1);

    logic [RATE_W-1:0] cnt;
    logic [2:0]        ext_sync;
    logic [HALF_W-1:0] half_cnt;
    logic              int_tick;
    logic              ext_rise;

    assign int_tick = (cnt >= rate);
    assign ext_rise = ext_sync[1] & ~ext_sync[2];
    assign tick     = ext_sel ? ext_rise : int_tick;

    // Divide the system clock by rate + 1
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (int_tick) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    // Synchronise the external clock and keep the previous value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sync <= '0;
        else        ext_sync <= {ext_sync[1:0], ext_clk};
    end

    // Toggle the bit clock every OSR/2 ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt <= '0;
            bit_clk  <= 1'b0;
        end else if (tick) begin
            if (half_cnt == HALF_LAST) begin
                half_cnt <= '0;
                bit_clk  <= ~bit_clk;
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sio_tx.sv
// Transmit engine. On enable it shifts out one frame of ones, then sends
// buffered bytes. Assumes the format stays stable while a frame is in flight.
module sio_tx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  fmt_t              fmt,
    input  logic              have_data,
    input  logic [DATA_W-1:0] data,
    output logic              take,
    output logic              txd
);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);

    typedef enum logic [1:0] {TX_OFF, TX_IDLE, TX_SHIFT} tx_st_t;
    tx_st_t             st;
    logic [FRAME_W-1:0] frm;
    logic [IDX_W-1:0]   left;
    logic [SUB_W-1:0]   sub;

    assign take = en && (st == TX_IDLE) && have_data;
    assign txd  = (st == TX_SHIFT) ? frm[0] : 1'b1;

    // Sequence: idle-frame preamble after enable, then load and shift frames
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st   <= TX_OFF;
            frm  <= '1;
            left <= '0;
            sub  <= '0;
        end else begin
            case (st)
                TX_OFF: begin
                    st   <= TX_SHIFT;
                    frm  <= '1;
                    left <= frame_bits(fmt);
                    sub  <= '0;
                end
                TX_IDLE: if (have_data) begin
                    st   <= TX_SHIFT;
                    frm  <= build_frame(data, fmt);
                    left <= frame_bits(fmt);
                    sub  <= '0;
                end
                TX_SHIFT: if (tick) begin
                    if (sub == SUB_LAST) begin
                        sub <= '0;
                        frm <= {1'b1, frm[FRAME_W-1:1]};
                        if (left == IDX_W'(1)) st <= TX_IDLE;
                        else                   left <= left - 1'b1;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                end
                default: st <= TX_OFF;
            endcase
        end
    end
endmodule

// File: rtl/sio_rx.sv
// Receive engine. It hunts for a falling edge, confirms the start bit at its
// middle, then samples each following bit at its middle. Assumes rxd is
// already synchronised. Only the first stop bit is checked.
module sio_rx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  fmt_t              fmt,
    input  logic              rxd,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              par_err,
    output logic              frm_err
);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
    localparam logic [SUB_W-1:0] SUB_MID  = SUB_W'(OSR / 2 - 1);

    typedef enum logic {RX_HUNT, RX_RUN} rx_st_t;
    rx_st_t            st;
    logic [SUB_W-1:0]  sub;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] sh;
    logic              rpar;
    logic [IDX_W-1:0]  par_idx;
    logic [IDX_W-1:0]  stop_idx;
    logic [DATA_W-1:0] fin_data;
    logic              exp_par;

    assign par_idx  = IDX_W'(data_len(fmt) + 1);
    assign stop_idx = par_idx + (fmt.par_en ? IDX_W'(1) : IDX_W'(0));
    assign fin_data = fmt.len7 ? {1'b0, sh[DATA_W-1:1]} : sh;
    assign exp_par  = (^fin_data) ^ fmt.par_odd;

    // Hunt, sample at mid-bit, and report the frame at its first stop bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= RX_HUNT; sub <= '0; idx <= '0; sh <= '0; rpar <= 1'b0;
            done <= 1'b0; rx_data <= '0; par_err <= 1'b0; frm_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                st <= RX_HUNT;
            end else if (st == RX_HUNT) begin
                if (!rxd) begin
                    st <= RX_RUN; sub <= '0; idx <= '0;
                end
            end else if (tick) begin
                sub <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
                if (sub == SUB_LAST) idx <= idx + 1'b1;
                if (sub == SUB_MID) begin
                    if (idx == '0) begin
                        if (rxd) st <= RX_HUNT;
                    end else if (idx == stop_idx) begin
                        done    <= 1'b1;
                        rx_data <= fin_data;
                        frm_err <= ~rxd;
                        par_err <= fmt.par_en && (rpar != exp_par);
                        st      <= RX_HUNT;
                    end else if (fmt.par_en && idx == par_idx) begin
                        rpar <= rxd;
                    end else begin
                        sh <= {rxd, sh[DATA_W-1:1]};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sio_core.sv
// Serial port top: register file, status flags, pin enables, and the
// baud, transmit and receive engines. Assumes single-cycle bus strobes.
module sio_core
    import sio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [2:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             ext_clk_in,
    output logic             sclk_out,
    output logic             sclk_oe,
    output logic             txd_out,
    output logic             txd_oe,
    input  logic             rxd_in
);
    logic              tx_on, rx_on, pin_en;
    logic [1:0]        clk_sel;
    fmt_t              fmt;
    logic              sync_mode;
    logic [RATE_W-1:0] rate;
    logic [DATA_W-1:0] tdr, rdr;
    logic              txe, rxf, perr, ferr, ovr;
    logic [1:0]        rxd_s;
    logic              tick, take, rx_done, rx_perr, rx_ferr;
    logic [DATA_W-1:0] rx_data;
    logic              wr_tx, wr_stat, rd_rx;

    assign sync_mode = fmt.sync;
    assign wr_tx   = bus_wr && (bus_addr == A_TXBUF);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign rd_rx   = bus_rd && (bus_addr == A_RXBUF);
    assign txd_oe  = pin_en;
    assign sclk_oe = (clk_sel == 2'b01) && (!sync_mode || rx_on);

    // Configuration registers and the transmit buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_on <= 1'b0; rx_on <= 1'b0; clk_sel <= 2'b00; pin_en <= 1'b0;
            fmt <= '0; rate <= '0; tdr <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  {clk_sel, rx_on, tx_on} <= bus_wdata[3:0];
                A_FMT:   fmt    <= fmt_t'(bus_wdata[4:0]);
                A_RATE:  rate   <= RATE_W'(bus_wdata);
                A_TXBUF: tdr    <= bus_wdata[DATA_W-1:0];
                A_PIN:   pin_en <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    // Status flags, receive buffer and overrun handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txe <= 1'b1; rxf <= 1'b0; perr <= 1'b0; ferr <= 1'b0; ovr <= 1'b0; rdr <= '0;
        end else begin
            if (!tx_on)     txe <= 1'b1;
            else if (wr_tx) txe <= 1'b0;
            else if (take)  txe <= 1'b1;
            if (rx_done && rx_on) begin
                if (rxf) begin
                    ovr <= 1'b1;
                end else begin
                    rxf  <= 1'b1;
                    rdr  <= rx_data;
                    perr <= perr | rx_perr;
                    ferr <= ferr | rx_ferr;
                end
            end else if (rd_rx) begin
                rxf <= 1'b0;
            end
            if (wr_stat) begin
                if (!bus_wdata[2]) perr <= 1'b0;
                if (!bus_wdata[3]) ferr <= 1'b0;
                if (!bus_wdata[4]) ovr  <= 1'b0;
            end
        end
    end

    // Two-stage synchroniser for the receive line
    always_ff @(posedge clk) begin
        if (!rst_n) rxd_s <= 2'b11;
        else        rxd_s <= {rxd_s[0], rxd_in};
    end

    // Register read multiplexer
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = BUS_W'({clk_sel, rx_on, tx_on});
            A_FMT:   bus_rdata = BUS_W'(fmt);
            A_RATE:  bus_rdata = BUS_W'(rate);
            A_STAT:  bus_rdata = BUS_W'({ovr, ferr, perr, rxf, txe});
            A_RXBUF: bus_rdata = BUS_W'(rdr);
            A_PIN:   bus_rdata = BUS_W'(pin_en);
            default: bus_rdata = '0;
        endcase
    end

    sio_baud #(.RATE_W(RATE_W), .OSR(OSR)) u_baud (
        .clk(clk), .rst_n(rst_n), .ext_sel(clk_sel[1]), .rate(rate),
        .ext_clk(ext_clk_in), .tick(tick), .bit_clk(sclk_out)
    );

    sio_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(tx_on && !sync_mode), .fmt(fmt),
        .have_data(!txe), .data(tdr), .take(take), .txd(txd_out)
    );

    sio_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(rx_on && !sync_mode), .fmt(fmt),
        .rxd(rxd_s[1]), .done(rx_done), .rx_data(rx_data),
        .par_err(rx_perr), .frm_err(rx_ferr)
    );
endmodule

// File: rtl/sio_core_chk.sv
// Property checker for sio_core, attached through bind. Observes only.
module sio_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [2:0] bus_addr,
    input logic       tx_on,
    input logic       rx_on,
    input logic       sync_mode,
    input logic       txe,
    input logic       rxf,
    input logic       perr,
    input logic       ferr,
    input logic       ovr,
    input logic [7:0] rdr,
    input logic       txd_out,
    input logic       sclk_oe
);
    // R6: turning the transmitter off empties the buffer flag
    p_txe_on_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_on) |=> txe);

    // R6: a disabled transmitter leaves the line at mark
    p_txd_mark_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |=> txd_out);

    // R5: a buffer write while enabled shows as not empty
    p_txbuf_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd4 && tx_on) |=> !txe);

    // R10: with the receiver off and no bus access, receive state holds
    p_rx_off_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_on && !bus_wr && !bus_rd) |=> $stable({rxf, perr, ferr, ovr, rdr}));

    // R9: error flags only fall through a status write
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((perr || ferr) && !(bus_wr && bus_addr == 3'd3)) |=> (perr || ferr));

    // R12: synchronous mode drives no clock without the receiver
    p_sync_oe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !rx_on) |-> !sclk_oe);
endmodule

bind sio_core sio_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .tx_on(tx_on), .rx_on(rx_on), .sync_mode(sync_mode), .txe(txe), .rxf(rxf),
    .perr(perr), .ferr(ferr), .ovr(ovr), .rdr(rdr), .txd_out(txd_out), .sclk_oe(sclk_oe)
);

// File: tb/sio_core_bench.sv
`timescale 1ns/1ps
module sio_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_clk_in = 1'b0, ext_run = 1'b0;
    logic       sclk_out, sclk_oe, txd_out, txd_oe;
    logic       rxd_in = 1'b1;
    int         nchk = 0, nfail = 0, cyc = 0;

    sio_core u_sio_core (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_in(ext_clk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .txd_out(txd_out), .txd_oe(txd_oe),
        .rxd_in(rxd_in)
    );

    initial forever #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    initial forever begin
        @(negedge clk);
        if (ext_run) ext_clk_in = ~ext_clk_in;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        nchk++;
        if (act < lo || act > hi) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Drive one frame on rxd_in at 16 clocks per bit (divisor 0)
    task automatic rx_send(input logic [7:0] d, input int nd, input int pmode,
                           input logic flip, input logic stopv);
        logic p;
        p = (pmode == 2) ^ flip;
        @(negedge clk);
        rxd_in = 1'b0; repeat (16) @(negedge clk);
        for (int i = 0; i < nd; i++) begin
            rxd_in = d[i]; p = p ^ d[i];
            repeat (16) @(negedge clk);
        end
        if (pmode != 0) begin rxd_in = p; repeat (16) @(negedge clk); end
        rxd_in = stopv; repeat (16) @(negedge clk);
        rxd_in = 1'b1; repeat (24) @(negedge clk);
    endtask

    // Wait for a start bit on txd_out and sample each bit at its middle
    task automatic tx_capture(input int bitcyc, input int nd, input int has_par, input int nstop,
                              input int t0, output logic [7:0] d, output logic pb,
                              output logic ok, output int delta);
        int n;
        n = 0; d = 8'h00; pb = 1'b0; ok = 1'b0; delta = -1;
        while (txd_out === 1'b1 && n < 4000) begin @(negedge clk); n++; end
        if (n >= 4000) return;
        delta = cyc - t0;
        repeat (bitcyc / 2) @(negedge clk);
        ok = (txd_out === 1'b0);
        for (int i = 0; i < nd; i++) begin repeat (bitcyc) @(negedge clk); d[i] = txd_out; end
        if (has_par != 0) begin repeat (bitcyc) @(negedge clk); pb = txd_out; end
        for (int i = 0; i < nstop; i++) begin
            repeat (bitcyc) @(negedge clk);
            ok = ok && (txd_out === 1'b1);
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(3'd3, v); chk("R1 status after reset", v, 8'h01);
        rd(3'd0, v); chk("R1 control after reset", v, 8'h00);
        chk("R1 txd_out idle", txd_out, 1'b1);
        chk("R1 txd_oe off", txd_oe, 1'b0);
        chk("R1 sclk_oe off", sclk_oe, 1'b0);
    endtask

    task automatic t_pin;
        wr(3'd6, 8'h01);
        chk("R2 txd_oe after pin enable", txd_oe, 1'b1);
        chk("R2 txd_out idle high", txd_out, 1'b1);
    endtask

    task automatic t_tx_preamble;
        logic [7:0] v, d; logic pb, ok; int t0, dl;
        wr(3'd0, 8'h01); t0 = cyc;
        wr(3'd4, 8'hA5);
        rd(3'd3, v); chk("R5 empty flag cleared by buffer write", v[0], 1'b0);
        tx_capture(16, 8, 0, 1, t0, d, pb, ok, dl);
        chk_rng("R3 idle frame before first start bit", dl, 155, 170);
        chk("R4 8N1 data", d, 8'hA5);
        chk("R4 8N1 start/stop", ok, 1'b1);
        rd(3'd3, v); chk("R5 empty flag set after load", v[0], 1'b1);
    endtask

    task automatic t_tx_fmt;
        logic [7:0] d; logic pb, ok; int dl;
        wr(3'd2, 8'd1); wr(3'd1, 8'h0E);
        wr(3'd4, 8'h3C);
        tx_capture(32, 8, 1, 2, cyc, d, pb, ok, dl);
        chk("R4 odd-parity data at divisor 1", d, 8'h3C);
        chk("R4 odd parity bit", pb, 1'b1);
        chk("R4 two stop bits", ok, 1'b1);
        repeat (40) @(negedge clk);
        wr(3'd2, 8'd0); wr(3'd1, 8'h00);
    endtask

    task automatic t_tx_off;
        logic [7:0] v;
        wr(3'd4, 8'h11); wr(3'd4, 8'h22);
        rd(3'd3, v); chk("R5 second byte pending", v[0], 1'b0);
        repeat (30) @(negedge clk);
        wr(3'd0, 8'h00);
        rd(3'd3, v); chk("R6 empty forced on disable", v[0], 1'b1);
        chk("R6 line back to mark", txd_out, 1'b1);
        repeat (40) @(negedge clk);
        chk("R6 line stays mark", txd_out, 1'b1);
    endtask

    task automatic t_rx_basic;
        logic [7:0] v;
        wr(3'd0, 8'h02);
        rx_send(8'h3C, 8, 0, 1'b0, 1'b1);
        rd(3'd3, v); chk("R7 receive full set", v[1], 1'b1);
        rd(3'd5, v); chk("R7 received byte", v, 8'h3C);
        rd(3'd3, v); chk("R7 read clears receive full", v[1], 1'b0);
    endtask

    task automatic t_overrun_and_off;
        logic [7:0] v, s0;
        rx_send(8'h81, 8, 0, 1'b0, 1'b1);
        rx_send(8'h7E, 8, 0, 1'b0, 1'b1);
        rd(3'd3, s0); chk("R8 overrun with full set", s0[4:1], 4'b1001);
        wr(3'd0, 8'h00);
        rd(3'd3, v); chk("R10 flags kept after receive disable", v, s0);
        rd(3'd5, v); chk("R8 R10 first byte kept", v, 8'h81);
        rx_send(8'h55, 8, 0, 1'b0, 1'b1);
        rd(3'd3, v); chk("R7 frame ignored while receiver off", v[1], 1'b0);
        wr(3'd3, 8'hFF);
        rd(3'd3, v); chk("R9 writing one keeps overrun", v[4], 1'b1);
        wr(3'd3, 8'h00);
        rd(3'd3, v); chk("R9 writing zero clears overrun", v[4], 1'b0);
    endtask

    task automatic t_errors;
        logic [7:0] v;
        wr(3'd0, 8'h02);
        rx_send(8'h42, 8, 0, 1'b0, 1'b0);
        rd(3'd3, v); chk("R9 framing error on zero stop", v[3], 1'b1);
        rd(3'd5, v); chk("R9 byte with framing error", v, 8'h42);
        wr(3'd3, 8'h00);
        rd(3'd3, v); chk("R9 framing error cleared", v[3], 1'b0);
        wr(3'd1, 8'h03);
        rx_send(8'h55, 7, 1, 1'b1, 1'b1);
        rd(3'd3, v); chk("R9 parity error on mismatch", v[2], 1'b1);
        rd(3'd5, v); chk("R9 seven-bit byte", v, 8'h55);
        wr(3'd3, 8'h00);
        rx_send(8'h2A, 7, 1, 1'b0, 1'b1);
        rd(3'd3, v); chk("R9 no parity error on match", v[2], 1'b0);
        rd(3'd5, v); chk("R7 seven-bit even byte", v, 8'h2A);
        wr(3'd1, 8'h00); wr(3'd0, 8'h00);
    endtask

    task automatic t_sclk;
        int tg; logic prev;
        wr(3'd0, 8'h04);
        chk("R11 async clock pin on without enables", sclk_oe, 1'b1);
        tg = 0; prev = sclk_out;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            if (sclk_out !== prev) tg++;
            prev = sclk_out;
        end
        chk_rng("R11 sclk toggles every 8 ticks", tg, 15, 17);
        wr(3'd1, 8'h10); wr(3'd0, 8'h04);
        chk("R12 sync clock off without receiver", sclk_oe, 1'b0);
        wr(3'd0, 8'h06);
        chk("R12 sync clock on with receiver", sclk_oe, 1'b1);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    endtask

    task automatic t_ext;
        logic [7:0] d; logic pb, ok; int t0, dl;
        ext_run = 1'b1;
        wr(3'd2, 8'd200);
        wr(3'd0, 8'h09); t0 = cyc;
        chk("R13 no clock output with external source", sclk_oe, 1'b0);
        wr(3'd4, 8'h96);
        tx_capture(32, 8, 0, 1, t0, d, pb, ok, dl);
        chk_rng("R13 divisor ignored, ticks from external clock", dl, 310, 345);
        chk("R13 data on external clock", d, 8'h96);
        ext_run = 1'b0;
        wr(3'd0, 8'h00); wr(3'd2, 8'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_pin();
        t_tx_preamble();
        t_tx_fmt();
        t_tx_off();
        t_rx_basic();
        t_overrun_and_off();
        t_errors();
        t_sclk();
        t_ext();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule